// File: doc/BRIEF.md
# Sixteen-Pin GPIO Expander Core with Edge Interrupts

This block is the register and pin logic of a 16-pin general-purpose I/O expander. A host reaches it through a byte-wide register port: an 8-bit address, write data with a write strobe, and a read strobe whose data appears on a registered read bus one cycle later. On the pin side it samples input levels through a synchronizer. It drives output levels, output enables and pull-resistor enables. Per pin it stores direction, output value, pull-up, pull-down, open-drain, input inversion, interrupt mask, a two-bit edge-sense code and a sticky event flag.

Each input first passes through the synchronizer and is then optionally inverted. The result is compared with its value one cycle earlier. A pin whose selected edge occurs while unmasked records a flag. While any flag is pending, the active-low summary interrupt stays low. The host clears flags by writing ones to them. A keyed two-write sequence to a dedicated address returns every register to its power-up value.

Top module: `gx_expander_core`

## Requirements
- R1: After reset, direction reads 0xFF at 0x0E and 0x0F, mask reads 0xFF at 0x12 and 0x13, and every other register reads 0x00. irq_n is 1 and pin_oe is all zeros.
- R2: Every one-bit-per-pin register keeps pins 7..0 at its base address and pins 15..8 one address lower. The pairs are pull-up 0x07/0x06, pull-down 0x09/0x08, open-drain 0x0B/0x0A, inversion 0x0D/0x0C, direction 0x0F/0x0E, data 0x11/0x10, mask 0x13/0x12 and event flags 0x19/0x18. Bit k of a byte belongs to pin 8*(byte index)+k. Any unmapped address reads 0x00.
- R3: A direction bit of 1 makes the pin an input, with its pin_oe bit at 0. A direction bit of 0 makes it an output: pin_oe is 1 and pin_out carries the written data bit.
- R4: When an output pin has its open-drain bit set, its driver is enabled only while its data bit is 0.
- R5: Reading the data address returns the synchronized pin level, XORed with that pin's inversion bit.
- R6: Pin n has a two-bit sense code at bits 2*(n mod 4)+1 : 2*(n mod 4) of address 0x17 - n/4. The codes are 00 no edge, 01 rising, 10 falling and 11 both.
- R7: An event flag sets when an unmasked pin shows its selected edge. An edge seen while the pin is masked is never recorded, and unmasking later does not recover it.
- R8: Writing a byte to an event-flag address clears the flags at the 1 positions and leaves the flags at the 0 positions unchanged.
- R9: irq_n is 0 while any event flag is set and returns to 1 once all flags are clear.
- R10: Edges are detected on the level after inversion, so with the inversion bit set a falling pin is seen as a rising edge.
- R11: Writing 0x12 and then 0x34 to address 0x7D restores every register to its reset value. Any write in between breaks the key, and the 0x34 write then has no effect.
- R12: The pull-up and pull-down registers appear on pull_up_en and pull_dn_en, one bit per pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 8 | Register address |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Registered read data |
| pin_in | input | NPINS | Raw pin levels |
| pin_out | output | NPINS | Output levels |
| pin_oe | output | NPINS | Output driver enables |
| pull_up_en | output | NPINS | Pull-up enables |
| pull_dn_en | output | NPINS | Pull-down enables |
| irq_n | output | 1 | Active-low summary interrupt |

## Verification
A wrong flag or mask bit shows up at irq_n one cycle after the flag register changes, and at the flag read port on the next read. A stale edge-history bit shows up as a missing or spurious flag about three cycles after a pin moves, which is the synchronizer delay plus the flag register. Configuration state reaches pin_oe, pin_out and the pull enables one registered cycle after the write. A broken reset key leaves previously written values readable straight after the 0x34 write.

// File: rtl/gx_pkg.sv
package gx_pkg;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned BYTE_W = 8;

  // base addresses hold the lowest-numbered pins; higher pins sit below
  localparam logic [ADDR_W-1:0] A_PULLUP = 8'h07;
  localparam logic [ADDR_W-1:0] A_PULLDN = 8'h09;
  localparam logic [ADDR_W-1:0] A_ODRAIN = 8'h0B;
  localparam logic [ADDR_W-1:0] A_INVERT = 8'h0D;
  localparam logic [ADDR_W-1:0] A_DIR    = 8'h0F;
  localparam logic [ADDR_W-1:0] A_DATA   = 8'h11;
  localparam logic [ADDR_W-1:0] A_MASK   = 8'h13;
  localparam logic [ADDR_W-1:0] A_SENSE  = 8'h17;
  localparam logic [ADDR_W-1:0] A_FLAG   = 8'h19;
  localparam logic [ADDR_W-1:0] A_KEY    = 8'h7D;

  localparam logic [BYTE_W-1:0] KEY_ARM  = 8'h12;
  localparam logic [BYTE_W-1:0] KEY_FIRE = 8'h34;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_ANY  = 2'b11
  } edge_sel_e;

  function automatic logic [ADDR_W-1:0] reg_at(logic [ADDR_W-1:0] base, int unsigned idx);
    return base - idx[ADDR_W-1:0];
  endfunction
endpackage

// File: rtl/gx_sync.sv
module gx_sync #(
  parameter int unsigned WIDTH  = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= '0;
          else     chain[s] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= '0;
          else     chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/gx_edge.sv
module gx_edge
  import gx_pkg::*;
#(
  parameter int unsigned NPINS = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NPINS-1:0]   lvl,
  input  logic [2*NPINS-1:0] sense,
  output logic [NPINS-1:0]   ev
);
  logic [NPINS-1:0] lvl_q;

  always_ff @(posedge clk) begin
    if (rst) lvl_q <= '0;
    else     lvl_q <= lvl;
  end

  generate
    for (genvar n = 0; n < NPINS; n++) begin : g_pin
      edge_sel_e sel;
      logic      rise, fall;
      assign sel  = edge_sel_e'(sense[2*n +: 2]);
      assign rise = lvl[n] & ~lvl_q[n];
      assign fall = ~lvl[n] & lvl_q[n];
      always_comb begin
        unique case (sel)
          EDGE_RISE: ev[n] = rise;
          EDGE_FALL: ev[n] = fall;
          EDGE_ANY:  ev[n] = rise | fall;
          default:   ev[n] = 1'b0;
        endcase
      end
    end
  endgenerate
endmodule

// File: rtl/gx_regs.sv
module gx_regs
  import gx_pkg::*;
#(
  parameter int unsigned NPINS = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                wr_en,
  input  logic [BYTE_W-1:0]   wdata,
  input  logic                rd_en,
  output logic [BYTE_W-1:0]   rd_data,
  input  logic [NPINS-1:0]    pin_lvl,
  input  logic [NPINS-1:0]    ev,
  output logic [NPINS-1:0]    dir_q,
  output logic [NPINS-1:0]    dout_q,
  output logic [NPINS-1:0]    pu_q,
  output logic [NPINS-1:0]    pd_q,
  output logic [NPINS-1:0]    od_q,
  output logic [NPINS-1:0]    inv_q,
  output logic [NPINS-1:0]    mask_q,
  output logic [2*NPINS-1:0]  sense_q,
  output logic [NPINS-1:0]    flag_q,
  output logic                soft_rst
);
  localparam int unsigned NB  = NPINS / BYTE_W;
  localparam int unsigned NSB = (2 * NPINS) / BYTE_W;

  logic             armed_q;
  logic [NPINS-1:0] flag_clr, flag_nx;
  logic [BYTE_W-1:0] rd_mux;

  assign soft_rst = wr_en && (addr == A_KEY) && (wdata == KEY_FIRE) && armed_q;

  always_comb begin
    flag_clr = '0;
    for (int i = 0; i < NB; i++)
      if (wr_en && addr == reg_at(A_FLAG, i)) flag_clr[BYTE_W*i +: BYTE_W] = wdata;
    flag_nx = (flag_q & ~flag_clr) | (ev & ~mask_q);
  end

  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      dir_q   <= '1;
      mask_q  <= '1;
      dout_q  <= '0;
      pu_q    <= '0;
      pd_q    <= '0;
      od_q    <= '0;
      inv_q   <= '0;
      sense_q <= '0;
      flag_q  <= '0;
      armed_q <= 1'b0;
    end else begin
      flag_q <= flag_nx;
      if (wr_en) armed_q <= (addr == A_KEY) && (wdata == KEY_ARM);
      for (int i = 0; i < NB; i++) begin
        if (wr_en && addr == reg_at(A_PULLUP, i)) pu_q[BYTE_W*i +: BYTE_W]   <= wdata;
        if (wr_en && addr == reg_at(A_PULLDN, i)) pd_q[BYTE_W*i +: BYTE_W]   <= wdata;
        if (wr_en && addr == reg_at(A_ODRAIN, i)) od_q[BYTE_W*i +: BYTE_W]   <= wdata;
        if (wr_en && addr == reg_at(A_INVERT, i)) inv_q[BYTE_W*i +: BYTE_W]  <= wdata;
        if (wr_en && addr == reg_at(A_DIR, i))    dir_q[BYTE_W*i +: BYTE_W]  <= wdata;
        if (wr_en && addr == reg_at(A_DATA, i))   dout_q[BYTE_W*i +: BYTE_W] <= wdata;
        if (wr_en && addr == reg_at(A_MASK, i))   mask_q[BYTE_W*i +: BYTE_W] <= wdata;
      end
      for (int j = 0; j < NSB; j++)
        if (wr_en && addr == reg_at(A_SENSE, j)) sense_q[BYTE_W*j +: BYTE_W] <= wdata;
    end
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NB; i++) begin
      if (addr == reg_at(A_PULLUP, i)) rd_mux = pu_q[BYTE_W*i +: BYTE_W];
      if (addr == reg_at(A_PULLDN, i)) rd_mux = pd_q[BYTE_W*i +: BYTE_W];
      if (addr == reg_at(A_ODRAIN, i)) rd_mux = od_q[BYTE_W*i +: BYTE_W];
      if (addr == reg_at(A_INVERT, i)) rd_mux = inv_q[BYTE_W*i +: BYTE_W];
      if (addr == reg_at(A_DIR, i))    rd_mux = dir_q[BYTE_W*i +: BYTE_W];
      if (addr == reg_at(A_DATA, i))   rd_mux = pin_lvl[BYTE_W*i +: BYTE_W];
      if (addr == reg_at(A_MASK, i))   rd_mux = mask_q[BYTE_W*i +: BYTE_W];
      if (addr == reg_at(A_FLAG, i))   rd_mux = flag_q[BYTE_W*i +: BYTE_W];
    end
    for (int j = 0; j < NSB; j++)
      if (addr == reg_at(A_SENSE, j)) rd_mux = sense_q[BYTE_W*j +: BYTE_W];
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= rd_mux;
  end
endmodule

// File: rtl/gx_expander_core.sv
module gx_expander_core
  import gx_pkg::*;
#(
  parameter int unsigned NPINS       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               wr_en,
  input  logic [BYTE_W-1:0]  wdata,
  input  logic               rd_en,
  output logic [BYTE_W-1:0]  rd_data,
  input  logic [NPINS-1:0]   pin_in,
  output logic [NPINS-1:0]   pin_out,
  output logic [NPINS-1:0]   pin_oe,
  output logic [NPINS-1:0]   pull_up_en,
  output logic [NPINS-1:0]   pull_dn_en,
  output logic               irq_n
);
  logic [NPINS-1:0]   pin_sync, pin_lvl, ev;
  logic [NPINS-1:0]   dir_q, dout_q, pu_q, pd_q, od_q, inv_q, mask_q, flag_q;
  logic [2*NPINS-1:0] sense_q;
  logic               soft_rst;

  gx_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(pin_in), .q(pin_sync)
  );

  assign pin_lvl = pin_sync ^ inv_q;

  gx_edge #(.NPINS(NPINS)) u_edge (
    .clk(clk), .rst(rst), .lvl(pin_lvl), .sense(sense_q), .ev(ev)
  );

  gx_regs #(.NPINS(NPINS)) u_regs (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .rd_en(rd_en), .rd_data(rd_data), .pin_lvl(pin_lvl), .ev(ev),
    .dir_q(dir_q), .dout_q(dout_q), .pu_q(pu_q), .pd_q(pd_q), .od_q(od_q),
    .inv_q(inv_q), .mask_q(mask_q), .sense_q(sense_q), .flag_q(flag_q),
    .soft_rst(soft_rst)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_out    <= '0;
      pin_oe     <= '0;
      pull_up_en <= '0;
      pull_dn_en <= '0;
      irq_n      <= 1'b1;
    end else begin
      pin_out    <= dout_q;
      pin_oe     <= ~dir_q & ~(od_q & dout_q);
      pull_up_en <= pu_q;
      pull_dn_en <= pd_q;
      irq_n      <= ~|flag_q;
    end
  end
endmodule

// File: rtl/gx_expander_chk.sv
module gx_expander_chk #(
  parameter int unsigned NPINS = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             irq_n,
  input logic [NPINS-1:0] flag,
  input logic [NPINS-1:0] mask,
  input logic [NPINS-1:0] ev,
  input logic [NPINS-1:0] dir,
  input logic [NPINS-1:0] pin_oe,
  input logic             soft_rst
);
  AST_IRQ_PENDING: assert property (@(posedge clk) disable iff (rst)
    (flag != '0) |=> !irq_n); // R9
  AST_IRQ_IDLE: assert property (@(posedge clk) disable iff (rst)
    (flag == '0) |=> irq_n); // R9
  AST_INPUT_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
    (dir != '0) |=> ((pin_oe & $past(dir)) == '0)); // R3
  AST_MASKED_NO_SET: assert property (@(posedge clk) disable iff (rst)
    (mask != '0) |=> ((flag & $past(mask) & ~$past(flag)) == '0)); // R7
  AST_EDGE_RECORDED: assert property (@(posedge clk) disable iff (rst)
    (!soft_rst && ((ev & ~mask) != '0)) |=> ((flag & $past(ev & ~mask)) == $past(ev & ~mask))); // R7
endmodule

bind gx_expander_core gx_expander_chk #(.NPINS(NPINS)) u_chk (
  .clk(clk), .rst(rst), .irq_n(irq_n), .flag(flag_q), .mask(mask_q),
  .ev(ev), .dir(dir_q), .pin_oe(pin_oe), .soft_rst(soft_rst)
);

// File: tb/tb_gx_expander_core.sv
`timescale 1ns/1ps
module tb_gx_expander_core;
  localparam int NP = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [7:0]    addr = '0;
  logic          wr_en = 1'b0;
  logic [7:0]    wdata = '0;
  logic          rd_en = 1'b0;
  logic [7:0]    rd_data;
  logic [NP-1:0] pin_in = '0;
  logic [NP-1:0] pin_out, pin_oe, pull_up_en, pull_dn_en;
  logic          irq_n;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  gx_expander_core #(.NPINS(NP)) dut (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .rd_en(rd_en), .rd_data(rd_data), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .pull_up_en(pull_up_en), .pull_dn_en(pull_dn_en),
    .irq_n(irq_n)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [7:0] exp);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    chk(req, {24'h0, rd_data}, {24'h0, exp});
  endtask

  task automatic pins(input logic [NP-1:0] v);
    @(negedge clk);
    pin_in = v;
    cyc(5);
  endtask

  task automatic t_reset;
    rd_chk("R1 dir lo", 8'h0F, 8'hFF);
    rd_chk("R1 dir hi", 8'h0E, 8'hFF);
    rd_chk("R1 mask lo", 8'h13, 8'hFF);
    rd_chk("R1 mask hi", 8'h12, 8'hFF);
    rd_chk("R1 pullup", 8'h07, 8'h00);
    rd_chk("R1 sense", 8'h15, 8'h00);
    rd_chk("R1 flags", 8'h19, 8'h00);
    chk("R1 irq_n", {31'h0, irq_n}, 32'h1);
    chk("R1 pin_oe", {16'h0, pin_oe}, 32'h0);
  endtask

  task automatic t_layout;
    wr(8'h0F, 8'hA5);
    wr(8'h0E, 8'h3C);
    wr(8'h10, 8'h12);
    wr(8'h11, 8'h34);
    cyc(2);
    chk("R3 pin_oe from direction", {16'h0, pin_oe}, 32'h0000C35A);
    chk("R2 R3 pin_out byte order", {16'h0, pin_out}, 32'h00001234);
    rd_chk("R2 dir hi byte", 8'h0E, 8'h3C);
    rd_chk("R2 dir lo byte", 8'h0F, 8'hA5);
    rd_chk("R2 unmapped", 8'h30, 8'h00);
  endtask

  task automatic t_opendrain;
    wr(8'h0E, 8'h00);
    wr(8'h0F, 8'h00);
    wr(8'h0B, 8'h0F);
    wr(8'h11, 8'h05);
    wr(8'h10, 8'h00);
    cyc(2);
    chk("R4 open-drain enables", {16'h0, pin_oe}, 32'h0000FFFA);
    chk("R3 pin_out", {16'h0, pin_out}, 32'h00000005);
    wr(8'h0B, 8'h00);
    wr(8'h0E, 8'hFF);
    wr(8'h0F, 8'hFF);
    cyc(2);
    chk("R3 all inputs", {16'h0, pin_oe}, 32'h0);
  endtask

  task automatic t_readpins;
    pins(16'h8001);
    rd_chk("R5 pins lo", 8'h11, 8'h01);
    rd_chk("R5 pins hi", 8'h10, 8'h80);
    wr(8'h0D, 8'h01);
    rd_chk("R5 inverted pin0", 8'h11, 8'h00);
    wr(8'h0D, 8'h00);
    pins(16'h0000);
    rd_chk("R5 pins low", 8'h11, 8'h00);
  endtask

  task automatic t_pulls;
    wr(8'h06, 8'h12);
    wr(8'h07, 8'h34);
    wr(8'h08, 8'hAB);
    wr(8'h09, 8'hCD);
    cyc(2);
    chk("R12 pull_up_en", {16'h0, pull_up_en}, 32'h00001234);
    chk("R12 pull_dn_en", {16'h0, pull_dn_en}, 32'h0000ABCD);
  endtask

  task automatic t_edges;
    pins(16'h0020);
    wr(8'h17, 8'h01);
    wr(8'h16, 8'h08);
    wr(8'h14, 8'h30);
    wr(8'h12, 8'h00);
    wr(8'h13, 8'h00);
    cyc(2);
    rd_chk("R7 no flags after unmask", 8'h19, 8'h00);
    chk("R9 idle irq_n", {31'h0, irq_n}, 32'h1);
    pins(16'h0221);
    rd_chk("R6 R7 rise pin0", 8'h19, 8'h01);
    rd_chk("R6 pin9 sense off", 8'h18, 8'h00);
    chk("R9 irq_n asserted", {31'h0, irq_n}, 32'h0);
    wr(8'h19, 8'h01);
    cyc(1);
    rd_chk("R8 clear pin0", 8'h19, 8'h00);
    chk("R9 irq_n released", {31'h0, irq_n}, 32'h1);
    pins(16'h0201);
    rd_chk("R6 fall pin5", 8'h19, 8'h20);
    wr(8'h19, 8'h00);
    rd_chk("R8 zero write keeps flag", 8'h19, 8'h20);
    wr(8'h19, 8'h20);
    pins(16'h0200);
    rd_chk("R6 rise-only ignores fall", 8'h19, 8'h00);
    pins(16'h4200);
    rd_chk("R6 both: rise pin14", 8'h18, 8'h40);
    wr(8'h18, 8'h40);
    pins(16'h0200);
    rd_chk("R6 both: fall pin14", 8'h18, 8'h40);
    wr(8'h18, 8'hFF);
    wr(8'h0D, 8'h01);
    cyc(4);
    wr(8'h19, 8'hFF);
    pins(16'h0201);
    rd_chk("R10 inverted pin rises, no event", 8'h19, 8'h00);
    pins(16'h0200);
    rd_chk("R10 inverted pin falls, rising event", 8'h19, 8'h01);
    wr(8'h19, 8'hFF);
    wr(8'h0D, 8'h00);
    cyc(4);
    wr(8'h13, 8'h01);
    pins(16'h0201);
    pins(16'h0200);
    rd_chk("R7 masked edge dropped", 8'h19, 8'h00);
    wr(8'h13, 8'h00);
    cyc(3);
    rd_chk("R7 unmask recovers nothing", 8'h19, 8'h00);
    chk("R9 irq_n idle", {31'h0, irq_n}, 32'h1);
  endtask

  task automatic t_softreset;
    pins(16'h4200);
    rd_chk("R11 pending flag", 8'h18, 8'h40);
    wr(8'h7D, 8'h12);
    wr(8'h06, 8'h55);
    wr(8'h7D, 8'h34);
    cyc(2);
    rd_chk("R11 broken key keeps pullup", 8'h06, 8'h55);
    rd_chk("R11 broken key keeps flag", 8'h18, 8'h40);
    wr(8'h7D, 8'h12);
    wr(8'h7D, 8'h34);
    cyc(3);
    rd_chk("R11 dir restored", 8'h0F, 8'hFF);
    rd_chk("R11 mask restored", 8'h13, 8'hFF);
    rd_chk("R11 sense cleared", 8'h14, 8'h00);
    rd_chk("R11 flags cleared", 8'h18, 8'h00);
    chk("R11 pull_up_en cleared", {16'h0, pull_up_en}, 32'h0);
    chk("R11 irq_n released", {31'h0, irq_n}, 32'h1);
    chk("R11 pin_oe cleared", {16'h0, pin_oe}, 32'h0);
  endtask

  task automatic report;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    cyc(4);
    rst = 1'b0;
    cyc(2);
    t_reset();
    t_layout();
    t_opendrain();
    t_readpins();
    t_pulls();
    t_edges();
    t_softreset();
    done = 1'b1;
    report();
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      report();
    end
  end
endmodule